// File: doc/BRIEF.md
# USB Receive Endpoint Controller

This block runs one USB receive endpoint that takes host-to-device data. It sits behind a serial interface engine that has already decoded the packet. That engine presents three things: a token strobe with its kind, the payload bytes one at a time with a valid strobe, and an end-of-packet strobe with a flag that says whether the CRC was good. The block decides whether each packet is kept in its byte FIFO. It also picks the handshake to return: ACK, NAK, STALL, or no handshake at all.

The CPU side has a command register and a data port. The command register holds the receive enable, the option to ignore SETUP tokens, a flush request and a 2-bit warning threshold. The data port pops payload bytes in arrival order. A level output gives the number of committed bytes, and a warning flag reports when free space in the FIFO runs low.

A packet's bytes become visible to the CPU only when the packet is committed. A packet that fails or is refused is wound back to the last committed position. The receive enable clears itself after each accepted OUT data packet and after each STALL. This lets software pace the host one packet at a time.

Top module: `usb_rx_endpoint`

## Requirements
- R1: After reset, the command register reads 0x00, `rx_level` is 0, `rx_warn` is 0 and `hs_valid` is 0.
- R2: The command register is laid out as follows:
  - bit 0 is receive enable;
  - bit 2 is ignore-SETUP;
  - bit 3 is flush, which always reads 0;
  - bits 6:5 are the warning limit;
  - bits 1, 4 and 7 read 0.

  Writing 0xFF therefore reads back 0x65.
- R3: Tokens use the codes `tok_kind` 1 = OUT, 2 = SETUP and 3 = any other token. An OUT packet that arrives while receive enable is 0 is answered with NAK, and none of its bytes are stored.
- R4: An OUT packet with a good CRC that arrives while receive enable is 1 and `stall_req` is 0 behaves as follows:
  - its bytes are committed to the FIFO;
  - an ACK is returned;
  - receive enable reads 0 afterwards.

  Handshake timing: `hs_valid` pulses for one cycle, in the cycle after the end-of-packet strobe. `hs_code` is 0 = ACK, 1 = NAK, 2 = STALL.
- R5: A SETUP packet with a good CRC is stored and ACKed whatever the value of receive enable, and it leaves receive enable unchanged.
- R6: A SETUP that follows an accepted SETUP with no OUT or other token in between is ACKed, but its data is discarded. Any non-SETUP token in between makes the next SETUP be stored normally.
- R7: While ignore-SETUP is 1, a SETUP token produces no handshake and stores nothing.
- R8: While `stall_req` is 1, an OUT packet is answered with STALL, stores nothing, and clears receive enable.
- R9: A packet whose CRC flag is 0 at end-of-packet gets no handshake. Any bytes it wrote are rolled back, and receive enable is unchanged.
- R10: If a packet's bytes exceed the free space in the 64-byte FIFO, the packet is rolled back. An OUT packet is then answered with NAK, and a SETUP packet gets no handshake.
- R11: Flushing works as follows:
  - writing 1 to the flush bit empties the FIFO and zeroes all pointers;
  - writing 0 to the flush bit leaves the FIFO as it is;
  - a flush requested during a packet waits until that packet's end-of-packet has been handled, so that packet is still committed and acknowledged first.
- R12: `rx_warn` is 1 when the FIFO's free bytes are at or below the threshold set by the warning limit, and 0 otherwise. The limit code selects the threshold: 01 gives 4 bytes, 10 gives 8 bytes and 11 gives 16 bytes. Code 00 keeps `rx_warn` at 0.
- R13: `data_rdata` shows the oldest committed byte, and a `data_rd` pulse advances to the next byte. A pulse while `rx_level` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command register write data |
| cmd_rdata | output | 8 | Command register read value |
| data_rd | input | 1 | Pop one byte from the FIFO |
| data_rdata | output | 8 | Byte at the FIFO read position |
| rx_level | output | 7 | Committed bytes available to read |
| rx_warn | output | 1 | Free space at or below the warning limit |
| stall_req | input | 1 | Endpoint halted: OUT packets are answered with STALL |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | Token kind (1 OUT, 2 SETUP, 3 other) |
| byte_valid | input | 1 | Payload byte strobe |
| byte_data | input | 8 | Payload byte |
| eop_valid | input | 1 | End-of-packet strobe |
| eop_crc_ok | input | 1 | CRC of the finished packet was good |
| hs_valid | output | 1 | Handshake pulse |
| hs_code | output | 2 | Handshake kind (0 ACK, 1 NAK, 2 STALL) |

## Verification
A CPU flush request can land while a packet is still arriving, or in the very cycle its end-of-packet is handled. In both cases the flush must hold off until the commit and the handshake are done. The bench writes the flush bit in the middle of a packet's bytes, and again in the same cycle as the end-of-packet strobe. In each case it expects an ACK and a level that still includes the new packet in the cycle the handshake appears. It then expects the level to fall to zero one cycle later.

// File: rtl/usb_rx_ep_pkg.sv
package usb_rx_ep_pkg;

    typedef enum logic [1:0] {
        TOK_NONE  = 2'd0,
        TOK_OUT   = 2'd1,
        TOK_SETUP = 2'd2,
        TOK_OTHER = 2'd3
    } tok_kind_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2,
        HS_NONE  = 2'd3
    } hs_code_e;

    typedef enum logic [1:0] {
        EP_IDLE  = 2'd0,
        EP_STORE = 2'd1,
        EP_DROP  = 2'd2
    } ep_state_e;

    typedef struct packed {
        logic [1:0] lim;
        logic       ign_setup;
        logic       rx_en;
    } cmd_t;

    localparam int CMD_EN_BIT    = 0;
    localparam int CMD_IGN_BIT   = 2;
    localparam int CMD_FLUSH_BIT = 3;
    localparam int CMD_LIM_LSB   = 5;

    function automatic logic [4:0] warn_thr(input logic [1:0] code);
        case (code)
            2'b01:   return 5'd4;
            2'b10:   return 5'd8;
            2'b11:   return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          commit,
    input  logic          rollback,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [PW-1:0] level,
    output logic [PW-1:0] free,
    output logic          full
);
    // DEPTH must be a power of two: pointers wrap on their low AW bits.
    logic [PW-1:0] wp, cwp, rp;
    logic [PW-1:0] fill;
    logic [DW-1:0] mem [DEPTH];
    logic          do_write;

    assign fill     = wp - rp;
    assign level    = cwp - rp;
    assign free     = PW'(DEPTH) - fill;
    assign full     = (fill == PW'(DEPTH));
    assign do_write = wr_en && !full && !rollback && !flush;
    assign rd_data  = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            cwp <= '0;
            rp  <= '0;
        end else begin
            if (rollback)
                wp <= cwp;
            else if (do_write)
                wp <= wp + 1'b1;
            if (commit)
                cwp <= wp;
            if (rd_en && level != '0)
                rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_write)
            mem[wp[AW-1:0]] <= wr_data;
    end

    // R11: a flush leaves nothing behind
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (level == '0 && free == PW'(DEPTH)));

    // R10: the buffer never holds more than its depth
    a_r10_no_overrun: assert property (@(posedge clk) disable iff (rst)
        fill <= PW'(DEPTH));

endmodule

// File: rtl/rx_warn_gen.sv
module rx_warn_gen #(
    parameter int PW = 7
) (
    input  logic [1:0]    lim,
    input  logic [PW-1:0] free,
    output logic          warn
);
    logic [PW-1:0] thr;

    assign thr  = PW'(usb_rx_ep_pkg::warn_thr(lim));
    assign warn = (lim != 2'b00) && (free <= thr);

endmodule

// File: rtl/rx_ep_ctrl.sv
module rx_ep_ctrl
    import usb_rx_ep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tok_valid,
    input  logic [1:0] tok_kind,
    input  logic       byte_valid,
    input  logic       eop_valid,
    input  logic       eop_crc_ok,
    input  logic       rx_en,
    input  logic       ign_setup,
    input  logic       stall_req,
    input  logic       flush_req,
    input  logic       fifo_full,
    output logic       fifo_wr,
    output logic       fifo_commit,
    output logic       fifo_rollback,
    output logic       fifo_flush,
    output logic       rxen_clr,
    output logic       hs_valid,
    output logic [1:0] hs_code
);
    ep_state_e state;
    hs_code_e  drop_code;
    logic      pkt_setup;
    logic      ovf;
    logic      setup_seen;
    logic      flush_pend;
    logic      in_idle;
    logic      store_eop;
    logic      store_good;

    assign in_idle    = (state == EP_IDLE);
    assign fifo_flush = flush_pend && in_idle;
    assign fifo_wr    = (state == EP_STORE) && byte_valid && !eop_valid && !ovf;
    assign store_eop  = (state == EP_STORE) && eop_valid;
    assign store_good = eop_crc_ok && !ovf;
    assign fifo_commit   = store_eop && store_good;
    assign fifo_rollback = store_eop && !store_good;
    assign rxen_clr = (store_eop && store_good && !pkt_setup) ||
                      ((state == EP_DROP) && eop_valid && eop_crc_ok &&
                       drop_code == HS_STALL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= EP_IDLE;
            drop_code  <= HS_NONE;
            pkt_setup  <= 1'b0;
            ovf        <= 1'b0;
            setup_seen <= 1'b0;
            flush_pend <= 1'b0;
            hs_valid   <= 1'b0;
            hs_code    <= HS_NONE;
        end else begin
            hs_valid   <= 1'b0;
            flush_pend <= (flush_pend && !fifo_flush) || flush_req;
            case (state)
                EP_IDLE: begin
                    if (tok_valid) begin
                        ovf <= 1'b0;
                        case (tok_kind)
                            TOK_SETUP: begin
                                if (!ign_setup) begin
                                    if (setup_seen) begin
                                        state     <= EP_DROP;
                                        drop_code <= HS_ACK;
                                    end else begin
                                        state     <= EP_STORE;
                                        pkt_setup <= 1'b1;
                                    end
                                end
                            end
                            TOK_OUT: begin
                                setup_seen <= 1'b0;
                                pkt_setup  <= 1'b0;
                                if (stall_req) begin
                                    state     <= EP_DROP;
                                    drop_code <= HS_STALL;
                                end else if (!rx_en) begin
                                    state     <= EP_DROP;
                                    drop_code <= HS_NAK;
                                end else begin
                                    state <= EP_STORE;
                                end
                            end
                            default: setup_seen <= 1'b0;
                        endcase
                    end
                end
                EP_STORE: begin
                    if (eop_valid) begin
                        state <= EP_IDLE;
                        if (store_good) begin
                            hs_valid <= 1'b1;
                            hs_code  <= HS_ACK;
                            if (pkt_setup)
                                setup_seen <= 1'b1;
                        end else if (eop_crc_ok && !pkt_setup) begin
                            hs_valid <= 1'b1;
                            hs_code  <= HS_NAK;
                        end
                    end else if (byte_valid && fifo_full) begin
                        ovf <= 1'b1;
                    end
                end
                EP_DROP: begin
                    if (eop_valid) begin
                        state <= EP_IDLE;
                        if (eop_crc_ok) begin
                            hs_valid <= 1'b1;
                            hs_code  <= drop_code;
                        end
                    end
                end
                default: state <= EP_IDLE;
            endcase
        end
    end

    // R4: a handshake is a single-cycle pulse
    a_r4_hs_pulse: assert property (@(posedge clk) disable iff (rst)
        hs_valid |=> !hs_valid);

    // R9: a rolled-back packet is never acknowledged
    a_r9_no_ack_on_rollback: assert property (@(posedge clk) disable iff (rst)
        fifo_rollback |=> !(hs_valid && hs_code == HS_ACK));

endmodule

// File: rtl/usb_rx_endpoint.sv
module usb_rx_endpoint
    import usb_rx_ep_pkg::*;
#(
    parameter int  DEPTH = 64,
    localparam int LW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_wr,
    input  logic [7:0]    cmd_wdata,
    output logic [7:0]    cmd_rdata,
    input  logic          data_rd,
    output logic [7:0]    data_rdata,
    output logic [LW-1:0] rx_level,
    output logic          rx_warn,
    input  logic          stall_req,
    input  logic          tok_valid,
    input  logic [1:0]    tok_kind,
    input  logic          byte_valid,
    input  logic [7:0]    byte_data,
    input  logic          eop_valid,
    input  logic          eop_crc_ok,
    output logic          hs_valid,
    output logic [1:0]    hs_code
);
    cmd_t          cmd;
    logic          flush_req;
    logic          rxen_clr;
    logic          fifo_wr, fifo_commit, fifo_rollback, fifo_flush, fifo_full;
    logic [LW-1:0] fifo_free;
    logic          unused_wdata_bits;

    assign flush_req         = cmd_wr && cmd_wdata[CMD_FLUSH_BIT];
    assign unused_wdata_bits = ^{cmd_wdata[7], cmd_wdata[4], cmd_wdata[1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
        end else if (cmd_wr) begin
            cmd.rx_en     <= cmd_wdata[CMD_EN_BIT];
            cmd.ign_setup <= cmd_wdata[CMD_IGN_BIT];
            cmd.lim       <= cmd_wdata[CMD_LIM_LSB +: 2];
        end else if (rxen_clr) begin
            cmd.rx_en <= 1'b0;
        end
    end

    always_comb begin
        cmd_rdata                    = '0;
        cmd_rdata[CMD_EN_BIT]        = cmd.rx_en;
        cmd_rdata[CMD_IGN_BIT]       = cmd.ign_setup;
        cmd_rdata[CMD_LIM_LSB +: 2]  = cmd.lim;
    end

    rx_ep_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .tok_valid     (tok_valid),
        .tok_kind      (tok_kind),
        .byte_valid    (byte_valid),
        .eop_valid     (eop_valid),
        .eop_crc_ok    (eop_crc_ok),
        .rx_en         (cmd.rx_en),
        .ign_setup     (cmd.ign_setup),
        .stall_req     (stall_req),
        .flush_req     (flush_req),
        .fifo_full     (fifo_full),
        .fifo_wr       (fifo_wr),
        .fifo_commit   (fifo_commit),
        .fifo_rollback (fifo_rollback),
        .fifo_flush    (fifo_flush),
        .rxen_clr      (rxen_clr),
        .hs_valid      (hs_valid),
        .hs_code       (hs_code)
    );

    rx_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .flush    (fifo_flush),
        .wr_en    (fifo_wr),
        .wr_data  (byte_data),
        .commit   (fifo_commit),
        .rollback (fifo_rollback),
        .rd_en    (data_rd),
        .rd_data  (data_rdata),
        .level    (rx_level),
        .free     (fifo_free),
        .full     (fifo_full)
    );

    rx_warn_gen #(.PW(LW)) u_warn (
        .lim  (cmd.lim),
        .free (fifo_free),
        .warn (rx_warn)
    );

    // R1: the register is clear on leaving reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmd_rdata == 8'h00));

    // R4: an automatic clear of receive enable takes effect unless a write wins
    a_r4_rxen_clears: assert property (@(posedge clk) disable iff (rst)
        (rxen_clr && !cmd_wr) |=> !cmd_rdata[CMD_EN_BIT]);

    // R12: limit code 00 silences the warning
    a_r12_warn_disabled: assert property (@(posedge clk) disable iff (rst)
        (cmd.lim == 2'b00) |-> !rx_warn);

endmodule

// File: tb/usb_rx_endpoint_test.sv
`timescale 1ns/1ps
module usb_rx_endpoint_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_wr;
    logic [7:0] cmd_wdata;
    logic [7:0] cmd_rdata;
    logic       data_rd;
    logic [7:0] data_rdata;
    logic [6:0] rx_level;
    logic       rx_warn;
    logic       stall_req;
    logic       tok_valid;
    logic [1:0] tok_kind;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       eop_valid;
    logic       eop_crc_ok;
    logic       hs_valid;
    logic [1:0] hs_code;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    localparam logic [1:0] K_OUT = 2'd1, K_SETUP = 2'd2, K_OTHER = 2'd3;
    localparam logic [7:0] E_ACK = 8'h04, E_NAK = 8'h05, E_STALL = 8'h06, E_NONE = 8'h00;

    always #2.5 clk = ~clk;

    usb_rx_endpoint uut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .data_rd(data_rd), .data_rdata(data_rdata),
        .rx_level(rx_level), .rx_warn(rx_warn), .stall_req(stall_req),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .byte_valid(byte_valid),
        .byte_data(byte_data), .eop_valid(eop_valid), .eop_crc_ok(eop_crc_ok),
        .hs_valid(hs_valid), .hs_code(hs_code)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_cmd(input logic [7:0] v);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = v;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    // flush_at: 0 none, 1 during first byte, 2 in the end-of-packet cycle
    task automatic send_pkt(input logic [1:0] kind, input int n, input logic [7:0] base,
                            input logic crc, input int flush_at, output logic [7:0] hs);
        @(negedge clk);
        tok_valid = 1'b1; tok_kind = kind;
        @(negedge clk);
        tok_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1; byte_data = base + 8'(i);
            if (flush_at == 1 && i == 0) begin cmd_wr = 1'b1; cmd_wdata = 8'h08; end
            @(negedge clk);
            cmd_wr = 1'b0;
        end
        byte_valid = 1'b0;
        eop_valid = 1'b1; eop_crc_ok = crc;
        if (flush_at == 2) begin cmd_wr = 1'b1; cmd_wdata = 8'h08; end
        @(negedge clk);
        eop_valid = 1'b0; cmd_wr = 1'b0;
        hs = hs_valid ? {5'b0, 1'b1, hs_code} : 8'h00;
    endtask

    task automatic send_tok(input logic [1:0] kind);
        @(negedge clk);
        tok_valid = 1'b1; tok_kind = kind;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic read_bytes(input string tag, input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            chk(tag, data_rdata, base + 8'(i));
            data_rd = 1'b1;
            @(negedge clk);
            data_rd = 1'b0;
        end
    endtask

    task automatic do_flush();
        wr_cmd(8'h08);
        cyc();
    endtask

    task automatic t_reset();
        chk("R1 cmd", cmd_rdata, 8'h00);
        chk("R1 level", {1'b0, rx_level}, 8'h00);
        chk("R1 warn", {7'b0, rx_warn}, 8'h00);
        chk("R1 hs", {7'b0, hs_valid}, 8'h00);
    endtask

    task automatic t_regs();
        wr_cmd(8'hFF);
        chk("R2 readback", cmd_rdata, 8'h65);
        wr_cmd(8'h00);
        chk("R2 clear", cmd_rdata, 8'h00);
    endtask

    task automatic t_out();
        logic [7:0] hs;
        send_pkt(K_OUT, 3, 8'h00, 1'b1, 0, hs);
        chk("R3 nak", hs, E_NAK);
        chk("R3 level", {1'b0, rx_level}, 8'h00);
        wr_cmd(8'h01);
        send_pkt(K_OUT, 5, 8'h10, 1'b1, 0, hs);
        chk("R4 ack", hs, E_ACK);
        chk("R4 level", {1'b0, rx_level}, 8'd5);
        cyc();
        chk("R4 hs pulse", {7'b0, hs_valid}, 8'h00);
        chk("R4 rx_en cleared", cmd_rdata, 8'h00);
        wr_cmd(8'h00);
        chk("R11 write 0 no flush", {1'b0, rx_level}, 8'd5);
        read_bytes("R13 data", 5, 8'h10);
        chk("R13 level drained", {1'b0, rx_level}, 8'h00);
        data_rd = 1'b1; cyc(); data_rd = 1'b0;
        chk("R13 empty read", {1'b0, rx_level}, 8'h00);
    endtask

    task automatic t_setup();
        logic [7:0] hs;
        send_pkt(K_SETUP, 8, 8'h40, 1'b1, 0, hs);
        chk("R5 ack", hs, E_ACK);
        chk("R5 level", {1'b0, rx_level}, 8'd8);
        chk("R5 rx_en kept", cmd_rdata, 8'h00);
        send_pkt(K_SETUP, 8, 8'h80, 1'b1, 0, hs);
        chk("R6 dup ack", hs, E_ACK);
        chk("R6 dup dropped", {1'b0, rx_level}, 8'd8);
        send_tok(K_OTHER);
        send_pkt(K_SETUP, 4, 8'hC0, 1'b1, 0, hs);
        chk("R6 rearm ack", hs, E_ACK);
        chk("R6 rearm level", {1'b0, rx_level}, 8'd12);
        read_bytes("R13 setup1", 8, 8'h40);
        read_bytes("R6 setup2", 4, 8'hC0);
    endtask

    task automatic t_ignore();
        logic [7:0] hs;
        wr_cmd(8'h04);
        send_tok(K_OTHER);
        send_pkt(K_SETUP, 4, 8'h55, 1'b1, 0, hs);
        chk("R7 no hs", hs, E_NONE);
        cyc();
        chk("R7 no hs later", {7'b0, hs_valid}, 8'h00);
        chk("R7 level", {1'b0, rx_level}, 8'h00);
    endtask

    task automatic t_stall();
        logic [7:0] hs;
        wr_cmd(8'h01);
        stall_req = 1'b1;
        send_pkt(K_OUT, 3, 8'h22, 1'b1, 0, hs);
        stall_req = 1'b0;
        chk("R8 stall", hs, E_STALL);
        chk("R8 level", {1'b0, rx_level}, 8'h00);
        cyc();
        chk("R8 rx_en cleared", cmd_rdata, 8'h00);
    endtask

    task automatic t_crc();
        logic [7:0] hs;
        wr_cmd(8'h01);
        send_pkt(K_OUT, 4, 8'h33, 1'b0, 0, hs);
        chk("R9 out no hs", hs, E_NONE);
        chk("R9 out rollback", {1'b0, rx_level}, 8'h00);
        chk("R9 rx_en kept", cmd_rdata, 8'h01);
        send_pkt(K_SETUP, 4, 8'h33, 1'b0, 0, hs);
        chk("R9 setup no hs", hs, E_NONE);
        chk("R9 setup rollback", {1'b0, rx_level}, 8'h00);
        send_pkt(K_OUT, 2, 8'h70, 1'b1, 0, hs);
        chk("R9 next ok", hs, E_ACK);
        read_bytes("R9 next data", 2, 8'h70);
    endtask

    task automatic t_overflow();
        logic [7:0] hs;
        wr_cmd(8'h01);
        send_pkt(K_OUT, 60, 8'h00, 1'b1, 0, hs);
        chk("R10 fill ack", hs, E_ACK);
        chk("R10 fill level", {1'b0, rx_level}, 8'd60);
        wr_cmd(8'h01);
        send_pkt(K_OUT, 10, 8'hA0, 1'b1, 0, hs);
        chk("R10 out nak", hs, E_NAK);
        chk("R10 out rollback", {1'b0, rx_level}, 8'd60);
        send_pkt(K_SETUP, 10, 8'hA0, 1'b1, 0, hs);
        chk("R10 setup no hs", hs, E_NONE);
        chk("R10 setup rollback", {1'b0, rx_level}, 8'd60);
        wr_cmd(8'h20);
        chk("R12 lim01 free4", {7'b0, rx_warn}, 8'h01);
        wr_cmd(8'h00);
        chk("R12 lim00", {7'b0, rx_warn}, 8'h00);
        read_bytes("R10 data kept", 60, 8'h00);
        do_flush();
    endtask

    task automatic t_warn();
        logic [7:0] hs;
        wr_cmd(8'h01);
        send_pkt(K_OUT, 48, 8'h00, 1'b1, 0, hs);
        chk("R12 fill48", hs, E_ACK);
        wr_cmd(8'h60);
        chk("R12 lim11 free16", {7'b0, rx_warn}, 8'h01);
        wr_cmd(8'h40);
        chk("R12 lim10 free16", {7'b0, rx_warn}, 8'h00);
        wr_cmd(8'h20);
        chk("R12 lim01 free16", {7'b0, rx_warn}, 8'h00);
        wr_cmd(8'h41);
        send_pkt(K_OUT, 8, 8'h00, 1'b1, 0, hs);
        chk("R12 fill56", hs, E_ACK);
        chk("R12 lim10 free8", {7'b0, rx_warn}, 8'h01);
        do_flush();
        chk("R11 flush idle", {1'b0, rx_level}, 8'h00);
        chk("R12 after flush", {7'b0, rx_warn}, 8'h00);
    endtask

    task automatic t_flush();
        logic [7:0] hs;
        wr_cmd(8'h01);
        send_pkt(K_OUT, 6, 8'h90, 1'b1, 1, hs);
        chk("R11 mid ack", hs, E_ACK);
        chk("R11 mid deferred", {1'b0, rx_level}, 8'd6);
        cyc();
        chk("R11 mid done", {1'b0, rx_level}, 8'h00);
        wr_cmd(8'h01);
        send_pkt(K_OUT, 5, 8'hB0, 1'b1, 2, hs);
        chk("R11 eop ack", hs, E_ACK);
        chk("R11 eop deferred", {1'b0, rx_level}, 8'd5);
        cyc();
        chk("R11 eop done", {1'b0, rx_level}, 8'h00);
        wr_cmd(8'h01);
        send_pkt(K_OUT, 2, 8'hE0, 1'b1, 0, hs);
        chk("R11 ptrs zeroed", hs, E_ACK);
        read_bytes("R11 data after flush", 2, 8'hE0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_wr = 1'b0; cmd_wdata = '0; data_rd = 1'b0; stall_req = 1'b0;
        tok_valid = 1'b0; tok_kind = '0; byte_valid = 1'b0; byte_data = '0;
        eop_valid = 1'b0; eop_crc_ok = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cyc();
        t_reset();
        t_regs();
        t_out();
        t_setup();
        t_ignore();
        t_stall();
        t_crc();
        t_overflow();
        t_warn();
        t_flush();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule